// File: doc/BRIEF.md
# Dual Threshold and Rate Alarm Unit

This block watches a set of seven sensor readings and raises up to two independent alarms. Each alarm channel picks one reading, either its raw or its filtered form, and on every sample tick compares either the reading itself (level mode) or its change over a programmable number of samples (rate mode) against a signed threshold. The threshold register's top bit chooses whether the alarm fires above or below the limit.

The two alarm results appear as status bits and are ORed into an error/alarm summary flag. An optional indicator can drive either of two general-purpose lines with the OR of both alarms, with a programmable active level. Evaluation runs as a three-state sequence: IDLE waits for a tick; the IDLE to FETCH transition latches the selected readings and reads the history buffer; the FETCH to EVAL transition stores the new reading in history and computes the comparison; the EVAL to IDLE transition publishes the new status. Ticks that arrive in FETCH or EVAL are dropped.

Top module: `dual_alarm_unit`

## Requirements
- R1: While reset is asserted and after its release, the alarm status is 00, the summary flag is 0 and no indicator line is driven or set high.
- R2: A channel's 3-bit source code selects the reading: 0 = none (the channel never alarms), 1 = supply, 2 = X acceleration, 3 = Y acceleration, 4 = temperature, 5 = X incline, 6 = Y incline, 7 = rotation; code k selects input slot k-1.
- R3: Control fields: bit 15 is channel 2's rate enable and bits 14:12 its source; bit 11 is channel 1's rate enable and bits 10:8 its source; bit 7 (channel 2) and bit 6 (channel 1) pick the filtered input instead of the raw one.
- R4: Threshold register bit 15 = 1 alarms when the monitored value is strictly greater than the limit, 0 when strictly less. For sources 1 and 4 the reading's bits 11:0 and the limit's bits 11:0 are taken as unsigned; for all other sources bits 13:0 of both are two's complement.
- R5: In rate mode the monitored value is the newest reading minus the reading taken N accepted ticks earlier, N being the channel's 8-bit sample-count field, with 0 and 1 both meaning one.
- R6: In rate mode the alarm stays inactive until at least N earlier readings have been accepted since reset.
- R7: A tick sampled in IDLE is accepted; the resulting status appears after the third rising edge counted from the accepting edge, and status holds its value on all other edges.
- R8: A tick sampled during the two edges after an accepted tick is ignored and adds nothing to the history.
- R9: Status bit 1 reports channel 2 and bit 0 channel 1 (1 = active); the summary flag is their OR.
- R10: Control bit 2 enables the indicator, bit 1 sets its polarity (1 = high when active), bit 0 picks line 1 over line 0. When enabled only the picked line is driven, carrying the OR of both alarms; when disabled both enables and levels are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | One-cycle pulse: new readings are valid |
| raw_data | input | 7x14 | Unfiltered readings, slot 0 = source code 1 |
| filt_data | input | 7x14 | Filtered readings, same slot order |
| alarm_ctrl | input | 16 | Channel sources, rate and filter selects, indicator control |
| thr_a1 | input | 16 | Channel 1 direction bit and limit |
| thr_a2 | input | 16 | Channel 2 direction bit and limit |
| cnt_a1 | input | 8 | Channel 1 rate sample count |
| cnt_a2 | input | 8 | Channel 2 rate sample count |
| alarm_status | output | 2 | Bit 1 channel 2, bit 0 channel 1 |
| ea_flag | output | 1 | OR of both alarm bits |
| dio_oe | output | 2 | Indicator drive enable per line |
| dio_level | output | 2 | Indicator level per line |

## Verification
On every cycle the assertions check that status moves only three edges after a tick, that a channel with source code 0 never raises its bit, that at most one indicator line is driven and none while the indicator is off, and that reset clears the status. Threshold direction, unsigned versus signed handling, filtered selection, the rate window with its N=0 alias, the warm-up hold after reset and the dropping of a tick during evaluation depend on sequences of readings, so only the bench's scenarios against its queue-based model show them.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EVAL  = 2'd2
    } eval_state_e;

    typedef enum logic [2:0] {
        SRC_OFF    = 3'd0,
        SRC_SUPPLY = 3'd1,
        SRC_XACC   = 3'd2,
        SRC_YACC   = 3'd3,
        SRC_TEMP   = 3'd4,
        SRC_XINC   = 3'd5,
        SRC_YINC   = 3'd6,
        SRC_ROT    = 3'd7
    } src_code_e;

    // Supply and temperature readings are plain unsigned codes.
    function automatic logic src_is_unsigned(input logic [2:0] code);
        return (code == SRC_SUPPLY) || (code == SRC_TEMP);
    endfunction

endpackage

// File: rtl/alarm_src_mux.sv
module alarm_src_mux
    import alarm_pkg::*;
#(
    parameter int NSRC = 7,
    parameter int DW   = 14,
    parameter int UW   = 12,
    parameter int XW   = 16
) (
    input  logic [2:0]                 code,
    input  logic                       use_filt,
    input  logic [NSRC-1:0][DW-1:0]    raw_vals,
    input  logic [NSRC-1:0][DW-1:0]    filt_vals,
    output logic signed [XW-1:0]       value
);

    logic [DW-1:0] picked;
    logic [2:0]    slot;

    always_comb begin
        slot   = code - 3'd1;
        picked = '0;
        if (code != SRC_OFF) begin
            picked = use_filt ? filt_vals[slot] : raw_vals[slot];
        end
        if (src_is_unsigned(code)) begin
            value = XW'(picked[UW-1:0]);
        end else begin
            value = XW'($signed(picked));
        end
    end

endmodule

// File: rtl/alarm_hist_buf.sv
module alarm_hist_buf #(
    parameter int DW    = 16,
    parameter int LAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [LAG_W-1:0] lag,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    rd_data,
    output logic             lag_ok
);

    localparam int DEPTH = 2 ** LAG_W;

    logic [DW-1:0]    mem [DEPTH];
    logic [LAG_W-1:0] wr_ptr;
    logic [LAG_W:0]   fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (fill != (LAG_W+1)'(DEPTH)) begin
                fill <= fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[wr_ptr - lag];
        end
    end

    assign lag_ok = (fill >= {1'b0, lag});

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
#(
    parameter int DW = 14,
    parameter int UW = 12,
    parameter int XW = 16,
    parameter int TW = 16
) (
    input  logic [2:0]           code,
    input  logic                 rate_mode,
    input  logic                 hist_ok,
    input  logic signed [XW-1:0] cur,
    input  logic signed [XW-1:0] old,
    input  logic [TW-1:0]        thr_reg,
    output logic                 hit
);

    logic signed [XW-1:0] limit;
    logic signed [XW-1:0] metric;
    logic                 unused_thr;

    assign unused_thr = ^thr_reg[TW-2:DW];

    always_comb begin
        if (src_is_unsigned(code)) begin
            limit = XW'(thr_reg[UW-1:0]);
        end else begin
            limit = XW'($signed(thr_reg[DW-1:0]));
        end
        metric = rate_mode ? (cur - old) : cur;
        hit    = 1'b0;
        if ((code != SRC_OFF) && (!rate_mode || hist_ok)) begin
            hit = thr_reg[TW-1] ? (metric > limit) : (metric < limit);
        end
    end

endmodule

// File: rtl/dual_alarm_unit.sv
module dual_alarm_unit
    import alarm_pkg::*;
#(
    parameter int NSRC  = 7,
    parameter int DW    = 14,
    parameter int UW    = 12,
    parameter int CNT_W = 8,
    parameter int REG_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sample_tick,
    input  logic [NSRC-1:0][DW-1:0]   raw_data,
    input  logic [NSRC-1:0][DW-1:0]   filt_data,
    input  logic [REG_W-1:0]          alarm_ctrl,
    input  logic [REG_W-1:0]          thr_a1,
    input  logic [REG_W-1:0]          thr_a2,
    input  logic [CNT_W-1:0]          cnt_a1,
    input  logic [CNT_W-1:0]          cnt_a2,
    output logic [1:0]                alarm_status,
    output logic                      ea_flag,
    output logic [1:0]                dio_oe,
    output logic [1:0]                dio_level
);

    localparam int XW  = DW + 2;
    localparam int NCH = 2;

    eval_state_e      state_q, state_d;
    logic             accept;
    logic [NCH-1:0]   hit_now_w;
    logic [NCH-1:0]   hit_q;
    logic [NCH-1:0]   status_q;
    logic             any_alarm;
    logic             unused_ctrl;

    assign unused_ctrl = ^alarm_ctrl[5:3];
    assign accept      = (state_q == ST_IDLE) && sample_tick;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [2:0]           code;
        logic                 rate_en;
        logic                 filt_en;
        logic [REG_W-1:0]     thr;
        logic [CNT_W-1:0]     cnt;
        logic [CNT_W-1:0]     lag;
        logic signed [XW-1:0] sel_val;
        logic signed [XW-1:0] cur_q;
        logic [XW-1:0]        old_raw;
        logic                 ok_now;
        logic                 ok_q;
        logic                 hit_now;

        assign code    = alarm_ctrl[8 + 4*ch +: 3];
        assign rate_en = alarm_ctrl[11 + 4*ch];
        assign filt_en = alarm_ctrl[6 + ch];
        assign thr     = (ch == 0) ? thr_a1 : thr_a2;
        assign cnt     = (ch == 0) ? cnt_a1 : cnt_a2;
        assign lag     = (cnt == '0) ? CNT_W'(1) : cnt;

        alarm_src_mux #(.NSRC(NSRC), .DW(DW), .UW(UW), .XW(XW)) mux_i (
            .code      (code),
            .use_filt  (filt_en),
            .raw_vals  (raw_data),
            .filt_vals (filt_data),
            .value     (sel_val)
        );

        alarm_hist_buf #(.DW(XW), .LAG_W(CNT_W)) hist_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (accept),
            .wr_en   (state_q == ST_FETCH),
            .lag     (lag),
            .wr_data (cur_q),
            .rd_data (old_raw),
            .lag_ok  (ok_now)
        );

        alarm_cmp #(.DW(DW), .UW(UW), .XW(XW), .TW(REG_W)) cmp_i (
            .code      (code),
            .rate_mode (rate_en),
            .hist_ok   (ok_q),
            .cur       (cur_q),
            .old       ($signed(old_raw)),
            .thr_reg   (thr),
            .hit       (hit_now)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q <= '0;
                ok_q  <= 1'b0;
            end else if (accept) begin
                cur_q <= sel_val;
                ok_q  <= ok_now;
            end
        end

        assign hit_now_w[ch] = hit_now;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            hit_q    <= '0;
            status_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH) hit_q    <= hit_now_w;
            if (state_q == ST_EVAL)  status_q <= hit_q;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = sample_tick ? ST_FETCH : ST_IDLE;
            ST_FETCH: state_d = ST_EVAL;
            ST_EVAL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        alarm_status = status_q;
        any_alarm    = |status_q;
        ea_flag      = any_alarm;
        dio_oe       = '0;
        dio_level    = '0;
        if (alarm_ctrl[2]) begin
            dio_oe[alarm_ctrl[0]]    = 1'b1;
            dio_level[alarm_ctrl[0]] = alarm_ctrl[1] ? any_alarm : ~any_alarm;
        end
    end

endmodule

// File: rtl/dual_alarm_unit_chk.sv
module dual_alarm_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sample_tick,
    input logic [15:0] alarm_ctrl,
    input logic [1:0]  alarm_status,
    input logic [1:0]  dio_oe,
    input logic [1:0]  dio_level
);

    // R1: reset leaves status clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (alarm_status == 2'b00));

    // R7: status only moves three edges after a tick
    a_r7_change_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alarm_status) |-> $past(sample_tick, 3));

    // R2: channel 1 with no source never rises
    a_r2_off_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_status[0]) |-> ($past(alarm_ctrl[10:8], 3) != 3'd0));

    // R10: never both lines driven
    a_r10_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dio_oe));

    // R10: indicator off leaves lines quiet
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !alarm_ctrl[2] |-> (dio_oe == 2'b00 && dio_level == 2'b00));

endmodule

bind dual_alarm_unit dual_alarm_unit_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_tick  (sample_tick),
    .alarm_ctrl   (alarm_ctrl),
    .alarm_status (alarm_status),
    .dio_oe       (dio_oe),
    .dio_level    (dio_level)
);

// File: tb/dual_alarm_unit_tb_top.sv
module dual_alarm_unit_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample_tick = 1'b0;
    logic [6:0][13:0]  raw_data = '0;
    logic [6:0][13:0]  filt_data = '0;
    logic [15:0]       alarm_ctrl = '0;
    logic [15:0]       thr_a1 = '0;
    logic [15:0]       thr_a2 = '0;
    logic [7:0]        cnt_a1 = '0;
    logic [7:0]        cnt_a2 = '0;
    logic [1:0]        alarm_status;
    logic              ea_flag;
    logic [1:0]        dio_oe;
    logic [1:0]        dio_level;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    run_cmp  = 1'b0;
    bit    done     = 1'b0;
    logic [1:0] exp_status = 2'b00;
    int    hq0[$];
    int    hq1[$];

    always #4 clk = ~clk;

    dual_alarm_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_tick  (sample_tick),
        .raw_data     (raw_data),
        .filt_data    (filt_data),
        .alarm_ctrl   (alarm_ctrl),
        .thr_a1       (thr_a1),
        .thr_a2       (thr_a2),
        .cnt_a1       (cnt_a1),
        .cnt_a2       (cnt_a2),
        .alarm_status (alarm_status),
        .ea_flag      (ea_flag),
        .dio_oe       (dio_oe),
        .dio_level    (dio_level)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural model of one channel's monitored reading
    function automatic int model_val(input int ch);
        int code;
        logic [13:0] r;
        code = (ch == 1) ? int'(alarm_ctrl[14:12]) : int'(alarm_ctrl[10:8]);
        if (code == 0) return 0;
        r = ((ch == 1) ? alarm_ctrl[7] : alarm_ctrl[6]) ? filt_data[code-1] : raw_data[code-1];
        if (code == 1 || code == 4) return int'(r[11:0]);
        return int'($signed(r));
    endfunction

    function automatic bit model_hit(input int ch);
        int code, n, v, lim, m, sz;
        bit rate;
        logic [15:0] thr;
        code = (ch == 1) ? int'(alarm_ctrl[14:12]) : int'(alarm_ctrl[10:8]);
        rate = (ch == 1) ? alarm_ctrl[15] : alarm_ctrl[11];
        thr  = (ch == 1) ? thr_a2 : thr_a1;
        n    = (ch == 1) ? int'(cnt_a2) : int'(cnt_a1);
        if (n == 0) n = 1;
        if (code == 0) return 1'b0;
        v = model_val(ch);
        if (code == 1 || code == 4) lim = int'(thr[11:0]);
        else lim = int'($signed(thr[13:0]));
        m = v;
        if (rate) begin
            sz = (ch == 1) ? hq1.size() : hq0.size();
            if (sz < n) return 1'b0;
            m = v - ((ch == 1) ? hq1[sz-n] : hq0[sz-n]);
        end
        return thr[15] ? (m > lim) : (m < lim);
    endfunction

    function automatic logic [3:0] model_ind(input logic [1:0] st);
        logic [1:0] oe, lv;
        bit act;
        oe = 2'b00;
        lv = 2'b00;
        act = (st != 2'b00);
        if (alarm_ctrl[2]) begin
            oe = alarm_ctrl[0] ? 2'b10 : 2'b01;
            if (alarm_ctrl[1] ? act : !act) lv = oe;
        end
        return {oe, lv};
    endfunction

    // Compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_cmp && !done) begin
            chk(cur_req, "status", 16'(alarm_status), 16'(exp_status));
            chk("R9", "summary", 16'(ea_flag), 16'(exp_status != 2'b00));
            chk("R10", "indicator", 16'({dio_oe, dio_level}), 16'(model_ind(exp_status)));
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hq0.delete();
        hq1.delete();
        exp_status = 2'b00;
        repeat (3) @(negedge clk);
        chk("R1", "status in reset", 16'(alarm_status), 16'h0);
        chk("R1", "lines in reset", 16'({dio_oe, dio_level}), 16'h0);
        rst_n = 1'b1;
    endtask

    task automatic do_tick(input bit wide);
        logic [1:0] pre, nxt;
        int v0, v1;
        @(negedge clk);
        nxt[0] = model_hit(0);
        nxt[1] = model_hit(1);
        v0 = model_val(0);
        v1 = model_val(1);
        hq0.push_back(v0);
        hq1.push_back(v1);
        if (hq0.size() > 256) void'(hq0.pop_front());
        if (hq1.size() > 256) void'(hq1.pop_front());
        pre = exp_status;
        sample_tick = 1'b1;
        @(posedge clk); #1;
        if (!wide) sample_tick = 1'b0;
        @(posedge clk); #1;
        sample_tick = 1'b0;
        chk("R7", "held before update", 16'(alarm_status), 16'(pre));
        @(posedge clk); #1;
        exp_status = nxt;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        run_cmp = 1'b1;
        @(negedge clk);
        chk("R1", "summary after reset", 16'(ea_flag), 16'h0);

        // Level mode, channel 1 on X incline (code 5, slot 4), greater than 100
        cur_req    = "R4";
        alarm_ctrl = 16'h0500;
        thr_a1     = 16'h8064;
        raw_data[4] = 14'd150;
        do_tick(1'b0);
        chk("R4", "greater hit", 16'(alarm_status), 16'h1);
        raw_data[4] = 14'd50;
        do_tick(1'b0);
        chk("R4", "greater miss", 16'(alarm_status), 16'h0);

        // Less than a negative limit (-50)
        thr_a1 = {2'b00, 14'h3FCE};
        raw_data[4] = 14'h3FC4;
        do_tick(1'b0);
        chk("R4", "less negative hit", 16'(alarm_status), 16'h1);
        raw_data[4] = 14'h3FD8;
        do_tick(1'b0);
        chk("R4", "less negative miss", 16'(alarm_status), 16'h0);

        // Filtered input select for channel 1 (bit 6)
        cur_req     = "R3";
        alarm_ctrl  = 16'h0540;
        raw_data[4] = 14'h3FC4;
        filt_data[4] = 14'd0;
        do_tick(1'b0);
        chk("R3", "filtered chosen, no hit", 16'(alarm_status), 16'h0);
        raw_data[4]  = 14'd0;
        filt_data[4] = 14'h3FBA;
        do_tick(1'b0);
        chk("R3", "filtered chosen, hit", 16'(alarm_status), 16'h1);

        // Channel 2, temperature (code 4) unsigned, greater than 0x100
        cur_req     = "R4";
        alarm_ctrl  = 16'h4000;
        thr_a2      = 16'h8100;
        raw_data[3] = 14'h3F00;
        do_tick(1'b0);
        chk("R4", "unsigned temp hit on ch2", 16'(alarm_status), 16'h2);

        // Channel 2, supply (code 1) unsigned limit from bits 11:0 only
        alarm_ctrl  = 16'h1000;
        thr_a2      = 16'h3100;
        raw_data[0] = 14'h2005;
        do_tick(1'b0);
        chk("R4", "unsigned supply limit", 16'(alarm_status), 16'h2);

        // Disabled source never alarms
        cur_req    = "R2";
        alarm_ctrl = 16'h0000;
        thr_a1     = {2'b10, 14'h2000};
        thr_a2     = {2'b10, 14'h2000};
        do_tick(1'b0);
        chk("R2", "source code 0 silent", 16'(alarm_status), 16'h0);

        // Both channels on X incline
        cur_req     = "R9";
        alarm_ctrl  = 16'h5500;
        thr_a1      = 16'h8064;
        thr_a2      = 16'h00C8;
        raw_data[4] = 14'd150;
        do_tick(1'b0);
        chk("R9", "both bits", 16'(alarm_status), 16'h3);
        chk("R9", "summary both", 16'(ea_flag), 16'h1);

        // Rate mode on channel 2, Y acceleration (code 3, slot 2), N=3, > 20
        cur_req    = "R6";
        do_reset();
        alarm_ctrl = 16'hB000;
        thr_a2     = 16'h8014;
        cnt_a2     = 8'd3;
        raw_data[2] = 14'd0;   do_tick(1'b0);
        raw_data[2] = 14'd10;  do_tick(1'b0);
        raw_data[2] = 14'd300; do_tick(1'b0);
        chk("R6", "warm-up holds inactive", 16'(alarm_status), 16'h0);
        cur_req    = "R5";
        raw_data[2] = 14'd40;  do_tick(1'b0);
        chk("R5", "rate over 3 hit", 16'(alarm_status), 16'h2);
        raw_data[2] = 14'd45;  do_tick(1'b0);
        raw_data[2] = 14'd46;  do_tick(1'b0);
        chk("R5", "rate over 3 negative", 16'(alarm_status), 16'h0);
        raw_data[2] = 14'd330; do_tick(1'b0);
        cnt_a2 = 8'd0;
        raw_data[2] = 14'd335; do_tick(1'b0);
        chk("R5", "count 0 small step", 16'(alarm_status), 16'h0);
        raw_data[2] = 14'd360; do_tick(1'b0);
        chk("R5", "count 0 acts as 1", 16'(alarm_status), 16'h2);
        cnt_a2 = 8'd1;
        raw_data[2] = 14'd400; do_tick(1'b0);

        // Tick held into FETCH must not add a second history entry
        cur_req = "R8";
        cnt_a2  = 8'd2;
        raw_data[2] = 14'd500; do_tick(1'b1);
        raw_data[2] = 14'd510; do_tick(1'b0);
        chk("R8", "busy tick dropped", 16'(alarm_status), 16'h2);

        // Indicator routing and polarity
        cur_req    = "R10";
        alarm_ctrl = 16'hB007;
        @(negedge clk);
        chk("R10", "line 1 active high", 16'({dio_oe, dio_level}), 16'b1010);
        alarm_ctrl = 16'hB005;
        @(negedge clk);
        chk("R10", "line 1 active low", 16'({dio_oe, dio_level}), 16'b1000);
        alarm_ctrl = 16'hB004;
        @(negedge clk);
        chk("R10", "line 0 active low", 16'({dio_oe, dio_level}), 16'b0100);
        alarm_ctrl = 16'hB003;
        @(negedge clk);
        chk("R10", "indicator off", 16'({dio_oe, dio_level}), 16'b0000);
        alarm_ctrl = 16'hB004;
        raw_data[2] = 14'd515; do_tick(1'b0);
        @(negedge clk);
        chk("R10", "idle active low drives high", 16'({dio_oe, dio_level}), 16'b0101);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule